// File: doc/BRIEF.md
# Serial EEPROM Write-Protect Controller

This block holds the protection state of a two-wire serial EEPROM and rules on every write attempt. It receives transaction events already decoded at byte level by the bus engine: a write start with its 16-bit address, data-byte strobes with their data, a stop, and register-read requests. It also receives the external write-protect pin. For each data byte it returns an acknowledge decision. After a stop that commits anything nonvolatile, it pulses a start for the programming cycle. It tells the array side whether a given address may be written, and it returns a snapshot of the protection register.

The protection register lives at address 0xFFFF. Two volatile latches form an arming sequence: first the write-enable latch, then the register-write-enable latch. Three nonvolatile bits, a two-bit block-lock field and a hardware-protect enable, are modelled as flops that load at stop. When the pin is high and the hardware-protect enable bit is set, the nonvolatile register bits are frozen. The latches can still be written. Writes into block-locked array space are acknowledged but never programmed.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset, all protection bits are 0, a register read returns 0x00, and array-write permission is 0 for every address.
- R2: A register read captures the value in the cycle after the read request. The layout is: bit7 hardware-protect enable, bits 4:3 block-lock field (bit 4 high), bit2 register-write-enable latch, bit1 write-enable latch. Bits 6, 5 and 0 read as 0.
- R3: Writing 0x02 to 0xFFFF is acknowledged, sets the write-enable latch and clears the register-write-enable latch. Writing 0x00 while the register-write-enable latch is 0 is acknowledged and clears the write-enable latch. Neither write pulses the nonvolatile start.
- R4: Writing 0x04 or 0x06 sets the register-write-enable latch only if the write-enable latch is already 1. Otherwise the byte gets no acknowledge and nothing changes. The register-write-enable latch is never 1 while the write-enable latch is 0.
- R5: A register byte with a 1 in bit 0, 5 or 6 gets no acknowledge and changes nothing.
- R6: A register byte other than 0x00, 0x02, 0x04 or 0x06, written while the register-write-enable latch is 0, gets no acknowledge and changes nothing.
- R7: Any register byte other than 0x02, 0x04 or 0x06, written while the register-write-enable latch is 1, is acknowledged. At the next stop, bits 7 and 4:3 of that byte load into the nonvolatile bits, the nonvolatile start pulses for one cycle starting one cycle after the stop, and the register-write-enable latch clears.
- R8: A register write takes only its first data byte. Later bytes before the stop get no acknowledge and are ignored.
- R9: While the pin is high and the hardware-protect enable bit is 1, nonvolatile register bytes get no acknowledge. A pending nonvolatile update is dropped if this condition holds at the stop. Latch-only bytes are still accepted.
- R10: An array data byte (address not 0xFFFF) is acknowledged exactly when the write-enable latch is 1. Without an acknowledge, the stop does not pulse the nonvolatile start.
- R11: Array-write permission for a 15-bit array address is: write-enable latch AND NOT locked. The block-lock field gives the locked range: 00 nothing, 01 addresses 0x6000 and above, 10 addresses 0x4000 and above, 11 the whole array.
- R12: An acknowledged array write to a locked address gives no nonvolatile start at the stop. One to an unlocked address pulses the start after the stop and clears the register-write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_pin_i | input | 1 | External write-protect pin |
| wr_start_i | input | 1 | Write transaction start, address valid |
| addr_i | input | 16 | Transaction address |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop event |
| rd_req_i | input | 1 | Protection register read request |
| arr_addr_i | input | 15 | Array address for the permission query |
| ack_o | output | 1 | Acknowledge for the strobed data byte (combinational) |
| nv_start_o | output | 1 | One-cycle nonvolatile programming start |
| arr_wr_ok_o | output | 1 | Array write permitted at arr_addr_i |
| reg_rdata_o | output | 8 | Protection register snapshot |

## Verification
The hardest case to reach is the pin going high after a nonvolatile register byte has been acknowledged but before the stop. In that case the acknowledge has already been given, and the commit must still be dropped. The bench reaches it in stages. It first arms both latches and programs the hardware-protect enable bit with the pin low. It then re-arms, sends a clearing byte, raises the pin between that byte and the stop, and expects no pulse and an unchanged register. Block-lock ranges are checked at their exact boundary addresses for each field value.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;
  parameter int ADDR_W = 16;
  parameter int ARR_AW = 15;
  parameter int DATA_W = 8;

  localparam logic [ADDR_W-1:0] REG_ADDR = '1;
  localparam logic [DATA_W-1:0] RSV_MASK = 8'h61;

  localparam int BIT_WPEN = 7;
  localparam int BIT_BL1  = 4;
  localparam int BIT_BL0  = 3;
  localparam int BIT_RWEL = 2;
  localparam int BIT_WEL  = 1;

  localparam logic [DATA_W-1:0] VAL_SET_WEL  = 8'h02;
  localparam logic [DATA_W-1:0] VAL_RWEL_A   = 8'h04;
  localparam logic [DATA_W-1:0] VAL_RWEL_B   = 8'h06;
  localparam logic [DATA_W-1:0] VAL_CLR_WEL  = 8'h00;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WEL,
    OP_SET_RWEL,
    OP_CLR_WEL,
    OP_NV,
    OP_REJECT
  } reg_op_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_REG,
    TX_REG_DONE,
    TX_ARR
  } tx_state_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bl;
  } nv_bits_t;
endpackage

// File: rtl/wp_lock_map.sv
module wp_lock_map
  import eeprom_wp_pkg::*;
#(
  parameter int AW = ARR_AW
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    bl_i,
  output logic          locked_o
);
  localparam logic [AW-1:0] BASE_QTR  = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] BASE_HALF = {1'b1, {(AW-1){1'b0}}};

  always_comb begin
    unique case (bl_i)
      2'b00:   locked_o = 1'b0;
      2'b01:   locked_o = (addr_i >= BASE_QTR);
      2'b10:   locked_o = (addr_i >= BASE_HALF);
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_byte_eval.sv
module wp_byte_eval
  import eeprom_wp_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic              wel_i,
  input  logic              rwel_i,
  input  logic              hw_prot_i,
  output reg_op_e           op_o
);
  always_comb begin
    if ((data_i & RSV_MASK) != '0) begin
      op_o = OP_REJECT;
    end else if (data_i == VAL_SET_WEL) begin
      op_o = OP_SET_WEL;
    end else if (data_i == VAL_RWEL_A || data_i == VAL_RWEL_B) begin
      op_o = wel_i ? OP_SET_RWEL : OP_REJECT;
    end else if (rwel_i) begin
      op_o = hw_prot_i ? OP_REJECT : OP_NV;
    end else if (data_i == VAL_CLR_WEL) begin
      op_o = OP_CLR_WEL;
    end else begin
      op_o = OP_REJECT;
    end
  end
endmodule

// File: rtl/wp_prot_regs.sv
module wp_prot_regs
  import eeprom_wp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  reg_op_e  op_i,
  input  logic     commit_i,
  input  nv_bits_t nv_i,
  input  logic     rwel_clr_i,
  output logic     wel_o,
  output logic     rwel_o,
  output nv_bits_t nv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o  <= 1'b0;
      rwel_o <= 1'b0;
      nv_o   <= '0;
    end else begin
      if (commit_i) nv_o <= nv_i;
      if (rwel_clr_i) begin
        rwel_o <= 1'b0;
      end else begin
        case (op_i)
          OP_SET_WEL: begin
            wel_o  <= 1'b1;
            rwel_o <= 1'b0;
          end
          OP_SET_RWEL: rwel_o <= 1'b1;
          OP_CLR_WEL:  wel_o  <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eeprom_wp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_pin_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              rd_req_i,
  input  logic [ARR_AW-1:0] arr_addr_i,
  output logic              ack_o,
  output logic              nv_start_o,
  output logic              arr_wr_ok_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int N_MAP = 2;

  tx_state_e         tx_q, tx_d;
  logic [ARR_AW-1:0] txn_addr_q;
  logic              nv_pend_q, arr_pend_q;
  nv_bits_t          nv_pend_bits_q;

  logic     wel_q, rwel_q;
  nv_bits_t nv_q;
  logic     wpen_q;
  logic [1:0] bl_q;
  logic     hw_prot;
  logic     arr_txn;
  reg_op_e  byte_op, op_apply;
  logic     byte_evt, commit, arr_cycle, nv_start_d;

  logic [ARR_AW-1:0] map_addr [N_MAP];
  logic              map_lock [N_MAP];

  assign wpen_q   = nv_q.wpen;
  assign bl_q     = nv_q.bl;
  assign hw_prot  = wp_pin_i & wpen_q;
  assign arr_txn  = (tx_q == TX_ARR);
  assign byte_evt = data_vld_i & ~wr_start_i & ~stop_i;

  assign map_addr[0] = arr_addr_i;
  assign map_addr[1] = txn_addr_q;

  for (genvar g = 0; g < N_MAP; g++) begin : g_map
    wp_lock_map #(.AW(ARR_AW)) u_map (
      .addr_i  (map_addr[g]),
      .bl_i    (bl_q),
      .locked_o(map_lock[g])
    );
  end

  wp_byte_eval u_eval (
    .data_i   (data_i),
    .wel_i    (wel_q),
    .rwel_i   (rwel_q),
    .hw_prot_i(hw_prot),
    .op_o     (byte_op)
  );

  assign op_apply  = (tx_q == TX_REG && byte_evt) ? byte_op : OP_NONE;
  // hardware protect re-checked at stop: pin may rise after the byte
  assign commit    = stop_i & ~wr_start_i & nv_pend_q & ~hw_prot;
  assign arr_cycle = stop_i & ~wr_start_i & arr_pend_q;
  assign nv_start_d = commit | arr_cycle;

  wp_prot_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_apply),
    .commit_i  (commit),
    .nv_i      (nv_pend_bits_q),
    .rwel_clr_i(nv_start_d),
    .wel_o     (wel_q),
    .rwel_o    (rwel_q),
    .nv_o      (nv_q)
  );

  always_comb begin
    ack_o = 1'b0;
    if (data_vld_i) begin
      case (tx_q)
        TX_REG:  ack_o = (byte_op != OP_REJECT);
        TX_ARR:  ack_o = wel_q;
        default: ack_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    tx_d = tx_q;
    if (wr_start_i)          tx_d = (addr_i == REG_ADDR) ? TX_REG : TX_ARR;
    else if (stop_i)         tx_d = TX_IDLE;
    else if (byte_evt && tx_q == TX_REG) tx_d = TX_REG_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q           <= TX_IDLE;
      txn_addr_q     <= '0;
      nv_pend_q      <= 1'b0;
      nv_pend_bits_q <= '0;
      arr_pend_q     <= 1'b0;
      nv_start_o     <= 1'b0;
      reg_rdata_o    <= '0;
    end else begin
      tx_q       <= tx_d;
      nv_start_o <= nv_start_d;
      if (wr_start_i) begin
        txn_addr_q <= addr_i[ARR_AW-1:0];
        nv_pend_q  <= 1'b0;
        arr_pend_q <= 1'b0;
      end else if (stop_i) begin
        nv_pend_q  <= 1'b0;
        arr_pend_q <= 1'b0;
      end else if (byte_evt) begin
        if (op_apply == OP_NV) begin
          nv_pend_q      <= 1'b1;
          nv_pend_bits_q <= '{wpen: data_i[BIT_WPEN],
                              bl:   {data_i[BIT_BL1], data_i[BIT_BL0]}};
        end
        if (arr_txn && wel_q && !map_lock[1]) arr_pend_q <= 1'b1;
      end
      if (rd_req_i) begin
        reg_rdata_o           <= '0;
        reg_rdata_o[BIT_WPEN] <= wpen_q;
        reg_rdata_o[BIT_BL1]  <= bl_q[1];
        reg_rdata_o[BIT_BL0]  <= bl_q[0];
        reg_rdata_o[BIT_RWEL] <= rwel_q;
        reg_rdata_o[BIT_WEL]  <= wel_q;
      end
    end
  end

  assign arr_wr_ok_o = wel_q & ~map_lock[0];
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       nv_start_o,
  input logic       wel_i,
  input logic       rwel_i,
  input logic       wpen_i,
  input logic [1:0] bl_i,
  input logic       wp_pin_i,
  input logic       data_vld_i,
  input logic       ack_o,
  input logic       arr_txn_i,
  input logic       arr_wr_ok_o
);
  p_nv_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |-> $past(stop_i));

  p_rwel_clr_on_nv_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |-> !rwel_i);

  p_hw_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wp_pin_i && wpen_i) |-> ($stable(bl_i) && $stable(wpen_i)));

  p_arr_ack_wel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_i && arr_txn_i) |-> (ack_o == wel_i));

  p_arr_ok_wel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_ok_o |-> wel_i);

  p_rwel_needs_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwel_i |-> wel_i);
endmodule

bind eeprom_wp_ctrl wp_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .nv_start_o (nv_start_o),
  .wel_i      (wel_q),
  .rwel_i     (rwel_q),
  .wpen_i     (wpen_q),
  .bl_i       (bl_q),
  .wp_pin_i   (wp_pin_i),
  .data_vld_i (data_vld_i),
  .ack_o      (ack_o),
  .arr_txn_i  (arr_txn),
  .arr_wr_ok_o(arr_wr_ok_o)
);

// File: tb/tb_eeprom_wp_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_wp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_pin = 1'b0, wr_start = 1'b0, data_vld = 1'b0, stop = 1'b0, rd_req = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [14:0] arr_addr = '0;
  logic        ack, nv_start, arr_ok;
  logic [7:0]  rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  eeprom_wp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wp_pin_i(wp_pin), .wr_start_i(wr_start),
    .addr_i(addr), .data_vld_i(data_vld), .data_i(data), .stop_i(stop),
    .rd_req_i(rd_req), .arr_addr_i(arr_addr), .ack_o(ack),
    .nv_start_o(nv_start), .arr_wr_ok_o(arr_ok), .reg_rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_wr(input logic [15:0] a);
    @(negedge clk); wr_start = 1'b1; addr = a;
    @(posedge clk); #1 wr_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic exp_ack, input string tag);
    @(negedge clk); data_vld = 1'b1; data = d;
    #1 check({tag, " ack"}, ack, exp_ack);
    @(posedge clk); #1 data_vld = 1'b0;
  endtask

  task automatic end_wr(input logic exp_nv, input string tag);
    @(negedge clk); stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
    @(negedge clk); check({tag, " nv_start"}, nv_start, exp_nv);
  endtask

  task automatic rd_reg(input logic [7:0] exp, input string tag);
    @(negedge clk); rd_req = 1'b1;
    @(posedge clk); #1 rd_req = 1'b0;
    @(negedge clk); check({tag, " rdata"}, rdata, exp);
  endtask

  task automatic wr_reg(input logic [7:0] d, input logic exp_ack, input logic exp_nv, input string tag);
    start_wr(16'hFFFF);
    send_byte(d, exp_ack, tag);
    end_wr(exp_nv, tag);
  endtask

  task automatic wr_arr(input logic [15:0] a, input logic exp_ack, input logic exp_nv, input string tag);
    start_wr(a);
    send_byte(8'h5A, exp_ack, tag);
    end_wr(exp_nv, tag);
  endtask

  task automatic perm(input logic [14:0] a, input logic exp, input string tag);
    @(negedge clk); arr_addr = a;
    #1 check({tag, " arr_wr_ok"}, arr_ok, exp);
  endtask

  task automatic t_reset();
    rd_reg(8'h00, "R1");
    perm(15'h0000, 1'b0, "R1");
  endtask

  task automatic t_wel();
    wr_reg(8'h02, 1'b1, 1'b0, "R3 set wel");
    rd_reg(8'h02, "R3/R2");
    wr_reg(8'h06, 1'b1, 1'b0, "R4 set rwel");
    rd_reg(8'h06, "R4");
    wr_reg(8'h02, 1'b1, 1'b0, "R3 wel clears rwel");
    rd_reg(8'h02, "R3");
    wr_reg(8'h00, 1'b1, 1'b0, "R3 clr wel");
    rd_reg(8'h00, "R3");
  endtask

  task automatic t_rwel_gate();
    wr_reg(8'h06, 1'b0, 1'b0, "R4 06 no wel");
    rd_reg(8'h00, "R4");
    wr_reg(8'h04, 1'b0, 1'b0, "R4 04 no wel");
    rd_reg(8'h00, "R4");
    wr_reg(8'h02, 1'b1, 1'b0, "R3");
    wr_reg(8'h04, 1'b1, 1'b0, "R4 04 with wel");
    rd_reg(8'h06, "R4");
  endtask

  task automatic t_reserved();
    wr_reg(8'h07, 1'b0, 1'b0, "R5 bit0");
    rd_reg(8'h06, "R5");
    wr_reg(8'h26, 1'b0, 1'b0, "R5 bit5");
    rd_reg(8'h06, "R5");
    wr_reg(8'h46, 1'b0, 1'b0, "R5 bit6");
    rd_reg(8'h06, "R5");
  endtask

  task automatic t_bl_gate();
    wr_reg(8'h02, 1'b1, 1'b0, "R3");
    wr_reg(8'h88, 1'b0, 1'b0, "R6 nv without rwel");
    rd_reg(8'h02, "R6");
  endtask

  task automatic t_array_wel();
    wr_reg(8'h00, 1'b1, 1'b0, "R3");
    wr_arr(16'h0123, 1'b0, 1'b0, "R10 wel low");
    perm(15'h0123, 1'b0, "R10");
    wr_reg(8'h02, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_nv_reg();
    wr_reg(8'h06, 1'b1, 1'b0, "R7 arm");
    start_wr(16'hFFFF);
    send_byte(8'h08, 1'b1, "R7 bl01");
    send_byte(8'h00, 1'b0, "R8 second byte");
    end_wr(1'b1, "R7");
    rd_reg(8'h0A, "R7/R8");
  endtask

  task automatic t_range();
    perm(15'h7000, 1'b0, "R11 bl01 locked");
    perm(15'h6000, 1'b0, "R11 bl01 edge");
    perm(15'h5FFF, 1'b1, "R11 bl01 open");
    wr_arr(16'h7000, 1'b1, 1'b0, "R12 locked");
    wr_reg(8'h06, 1'b1, 1'b0, "R12 arm");
    rd_reg(8'h0E, "R12");
    wr_arr(16'h1000, 1'b1, 1'b1, "R12 open");
    rd_reg(8'h0A, "R12 rwel cleared");
    wr_reg(8'h06, 1'b1, 1'b0, "R7 arm");
    wr_reg(8'h10, 1'b1, 1'b1, "R7 bl10");
    rd_reg(8'h12, "R7");
    perm(15'h4000, 1'b0, "R11 bl10 locked");
    perm(15'h3FFF, 1'b1, "R11 bl10 open");
    wr_reg(8'h06, 1'b1, 1'b0, "R7 arm");
    wr_reg(8'h18, 1'b1, 1'b1, "R7 bl11");
    rd_reg(8'h1A, "R7");
    perm(15'h0000, 1'b0, "R11 bl11");
    wr_arr(16'h0000, 1'b1, 1'b0, "R12 all locked");
  endtask

  task automatic t_hw();
    wr_reg(8'h06, 1'b1, 1'b0, "R7 arm");
    wr_reg(8'h90, 1'b1, 1'b1, "R7 wpen");
    rd_reg(8'h92, "R7");
    @(negedge clk); wp_pin = 1'b1;
    wr_reg(8'h06, 1'b1, 1'b0, "R9 latch allowed");
    rd_reg(8'h96, "R9");
    wr_reg(8'h00, 1'b0, 1'b0, "R9 nv refused");
    rd_reg(8'h96, "R9");
    @(negedge clk); wp_pin = 1'b0;
    start_wr(16'hFFFF);
    send_byte(8'h00, 1'b1, "R9 pin low");
    @(negedge clk); wp_pin = 1'b1;
    end_wr(1'b0, "R9 pin rose before stop");
    rd_reg(8'h96, "R9");
    @(negedge clk); wp_pin = 1'b0;
    wr_reg(8'h00, 1'b1, 1'b1, "R9 unlocked clear");
    rd_reg(8'h02, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_wel();
    t_rwel_gate();
    t_reserved();
    t_bl_gate();
    t_array_wel();
    t_nv_reg();
    t_range();
    t_hw();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule